// File: doc/BRIEF.md
# Link Speed Bring-Up Sequencer

This block is the control sequencer that brings a serial link on a root port from reset to a trained state. It always starts training at the lowest speed. Starting at the higher speed can leave devices behind a switch undetected. Before it enables training, it clamps the maximum-speed field to first generation. It then waits for the link to report up and no longer training. If a configuration input allows second generation, it raises the cap to 2 and requests a directed speed change. It polls the speed-change readback at a programmable interval until the link clears it, and gives up after a bounded number of polls. It then waits once more for the link to come up before it reports success and the negotiated speed.

When any wait runs out, the block reports failure and pulses the receiver override controls for a programmable number of cycles. Both the data-enable override and the PLL-enable override are asserted together, which resets the PHY receiver. Done and fail are sticky until the next accepted start. A start that arrives while a sequence or a receiver pulse is in progress is ignored.

Top module: `lsb_seq`

## Requirements
- R1: After reset, max_speed_o is 1, speed_o is 0, and train_en_o, speed_chg_req_o, both override outputs, busy_o, done_o and fail_o are all 0.
- R2: An accepted start first drives max_speed_o to 1 and train_en_o low. train_en_o is raised only in a later cycle, and only while max_speed_o is 1.
- R3: With gen2_allow low, link-ok (link_up_i high and in_training_i low) during the first wait ends the sequence in done. speed_o takes cur_speed_i, max_speed_o stays 1 and no speed-change request is ever made.
- R4: With gen2_allow high, max_speed_o becomes 2 only after the first link-ok. speed_chg_req_o is raised only after that, and only while max_speed_o is 2.
- R5: speed_chg_req_o stays high until a poll sees speed_chg_i at 0. The block then waits for link-ok again, ends in done with speed_o equal to cur_speed_i, and leaves max_speed_o at 2.
- R6: Polls of speed_chg_i occur every poll_interval+1 cycles. If MAX_POLLS polls (default 200) all see the bit still set, speed_chg_req_o falls and fail_o rises on the same edge, after exactly MAX_POLLS*(poll_interval+1) cycles of request.
- R7: If link-ok is not seen within up_timeout+1 cycles of either link wait, the sequence ends in fail. Link-up while in_training_i is high does not count as link-ok.
- R8: On the edge that sets fail_o, both rx_data_ovrd_o and rx_pll_ovrd_o rise together. They stay high for exactly rxrst_hold cycles, then clear.
- R9: done_o and fail_o are never high together. Each stays high until a start is accepted, and is cleared on the edge that accepts it.
- R10: A start while busy_o is high is ignored. busy_o is high during a sequence and while the receiver override pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for a bring-up sequence |
| gen2_allow | input | 1 | Allow raising the cap to second generation after first link-up |
| up_timeout | input | TW | Link-up wait limit in cycles |
| poll_interval | input | TW | Cycles between speed-change polls, minus one |
| rxrst_hold | input | TW | Receiver override pulse length in cycles |
| link_up_i | input | 1 | Link-up status from the link |
| in_training_i | input | 1 | Link-still-training status from the link |
| speed_chg_i | input | 1 | Speed-change bit readback, cleared by the link when the change finishes |
| cur_speed_i | input | SPW | Current link speed status field |
| max_speed_o | output | SPW | Maximum link speed cap |
| train_en_o | output | 1 | Training enable |
| speed_chg_req_o | output | 1 | Directed speed-change request |
| rx_data_ovrd_o | output | 1 | Receiver data-enable override |
| rx_pll_ovrd_o | output | 1 | Receiver PLL-enable override |
| busy_o | output | 1 | Sequence or receiver pulse in progress |
| done_o | output | 1 | Sticky success flag |
| fail_o | output | 1 | Sticky failure flag |
| speed_o | output | SPW | Speed captured at success |

## Verification
The assertions assume the link behaves sensibly. speed_chg_i is only set while a request is outstanding. gen2_allow and the three timing inputs hold steady through a sequence. up_timeout, poll_interval and rxrst_hold are nonzero. The bench keeps to these assumptions with a behavioural link model. The model raises link-up only after a programmed delay following training enable. It drops the link and asserts the speed-change readback only in answer to the request. It reports the cap that was in force as the current speed. The timing inputs are fixed before each start.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CAP_GEN1, S_TRAIN, S_WAIT_UP, S_RAISE_CAP,
    S_SPEED_REQ, S_WAIT_SPEED, S_WAIT_UP2, S_DONE, S_FAIL
  } lsb_state_t;

  localparam logic [3:0] SPD_GEN1 = 4'd1;
  localparam logic [3:0] SPD_GEN2 = 4'd2;
endpackage

// File: rtl/lsb_timer.sv
module lsb_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= val;
    else            cnt_q <= step(cnt_q);
  end

  assign expired = (cnt_q == '0);

  assert_timer_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(val));
endmodule

// File: rtl/lsb_rx_pulse.sv
module lsb_rx_pulse #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [TW-1:0] hold,
  output logic          active
);
  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             left_q <= '0;
    else if (trig)          left_q <= hold;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && hold != '0) |=> active);
endmodule

// File: rtl/lsb_seq.sv
module lsb_seq
  import lsb_pkg::*;
#(
  parameter int TW        = 16,
  parameter int SPW       = 4,
  parameter int MAX_POLLS = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           gen2_allow,
  input  logic [TW-1:0]  up_timeout,
  input  logic [TW-1:0]  poll_interval,
  input  logic [TW-1:0]  rxrst_hold,
  input  logic           link_up_i,
  input  logic           in_training_i,
  input  logic           speed_chg_i,
  input  logic [SPW-1:0] cur_speed_i,
  output logic [SPW-1:0] max_speed_o,
  output logic           train_en_o,
  output logic           speed_chg_req_o,
  output logic           rx_data_ovrd_o,
  output logic           rx_pll_ovrd_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           fail_o,
  output logic [SPW-1:0] speed_o
);
  localparam int PCW = $clog2(MAX_POLLS + 1);
  localparam logic [PCW-1:0] LAST_POLL = PCW'(MAX_POLLS - 1);

  lsb_state_t     st_q;
  logic [PCW-1:0] poll_q;
  logic           tmr_load, tmr_exp, rx_act;
  logic [TW-1:0]  tmr_val;

  // named internal events
  logic link_ok, poll_hit, poll_last, fail_go, start_acc, seq_idle;
  assign link_ok   = link_up_i && !in_training_i;
  assign poll_hit  = (st_q == S_WAIT_SPEED) && tmr_exp;
  assign poll_last = (poll_q == LAST_POLL);
  assign seq_idle  = (st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_FAIL);
  assign busy_o    = !seq_idle || rx_act;
  assign start_acc = start && !busy_o;
  assign fail_go   = ((st_q == S_WAIT_UP || st_q == S_WAIT_UP2) && !link_ok && tmr_exp)
                   || (poll_hit && speed_chg_i && poll_last);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = up_timeout;
    unique case (st_q)
      S_TRAIN:      tmr_load = 1'b1;
      S_SPEED_REQ:  begin tmr_load = 1'b1; tmr_val = poll_interval; end
      S_WAIT_SPEED: if (poll_hit) begin
                      tmr_load = 1'b1;
                      tmr_val  = speed_chg_i ? poll_interval : up_timeout;
                    end
      default: ;
    endcase
  end

  lsb_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
  );

  lsb_rx_pulse #(.TW(TW)) u_rx (
    .clk(clk), .rst_n(rst_n), .trig(fail_go), .hold(rxrst_hold), .active(rx_act)
  );

  assign rx_data_ovrd_o = rx_act;
  assign rx_pll_ovrd_o  = rx_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q            <= S_IDLE;
      poll_q          <= '0;
      max_speed_o     <= SPW'(SPD_GEN1);
      train_en_o      <= 1'b0;
      speed_chg_req_o <= 1'b0;
      done_o          <= 1'b0;
      fail_o          <= 1'b0;
      speed_o         <= '0;
    end else begin
      if (fail_go) begin
        st_q            <= S_FAIL;
        fail_o          <= 1'b1;
        speed_chg_req_o <= 1'b0;
      end else begin
        unique case (st_q)
          S_IDLE, S_DONE, S_FAIL: if (start_acc) begin
            st_q    <= S_CAP_GEN1;
            done_o  <= 1'b0;
            fail_o  <= 1'b0;
            speed_o <= '0;
          end
          S_CAP_GEN1: begin
            max_speed_o <= SPW'(SPD_GEN1);
            train_en_o  <= 1'b0;
            st_q        <= S_TRAIN;
          end
          S_TRAIN: begin
            train_en_o <= 1'b1;
            st_q       <= S_WAIT_UP;
          end
          S_WAIT_UP: if (link_ok) begin
            if (gen2_allow) st_q <= S_RAISE_CAP;
            else begin
              st_q    <= S_DONE;
              done_o  <= 1'b1;
              speed_o <= cur_speed_i;
            end
          end
          S_RAISE_CAP: begin
            max_speed_o <= SPW'(SPD_GEN2);
            st_q        <= S_SPEED_REQ;
          end
          S_SPEED_REQ: begin
            speed_chg_req_o <= 1'b1;
            poll_q          <= '0;
            st_q            <= S_WAIT_SPEED;
          end
          S_WAIT_SPEED: if (poll_hit) begin
            if (!speed_chg_i) begin
              speed_chg_req_o <= 1'b0;
              st_q            <= S_WAIT_UP2;
            end else begin
              poll_q <= poll_q + 1'b1;
            end
          end
          S_WAIT_UP2: if (link_ok) begin
            st_q    <= S_DONE;
            done_o  <= 1'b1;
            speed_o <= cur_speed_i;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assert_train_after_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en_o) |-> max_speed_o == SPW'(SPD_GEN1));
  assert_req_at_gen2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    speed_chg_req_o |-> (max_speed_o == SPW'(SPD_GEN2)) && train_en_o);
  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < PCW'(MAX_POLLS));
  assert_done_needs_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(link_up_i && !in_training_i));
  assert_ovrd_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_data_ovrd_o) |-> fail_o && rx_pll_ovrd_o);
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start) |=> done_o);
  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start) |=> fail_o);
  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_o) |=> st_q != S_CAP_GEN1);
endmodule

// File: tb/sim_lsb_seq.sv
module sim_lsb_seq;
  localparam int TW = 16;
  localparam int MAXP = 200;
  localparam logic [15:0] NEVER = 16'hFFFF;
  localparam int P_INT = 3;
  localparam int HOLD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, gen2_allow = 1'b0;
  logic [TW-1:0] up_timeout = 16'd40, poll_interval = 16'(P_INT), rxrst_hold = 16'(HOLD);
  logic link_up_i, in_training_i, speed_chg_i;
  logic [3:0] cur_speed_i;
  logic [3:0] max_speed_o, speed_o;
  logic train_en_o, speed_chg_req_o, rx_data_ovrd_o, rx_pll_ovrd_o, busy_o, done_o, fail_o;

  always #4 clk = ~clk;

  lsb_seq #(.TW(TW), .SPW(4), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .gen2_allow(gen2_allow),
    .up_timeout(up_timeout), .poll_interval(poll_interval), .rxrst_hold(rxrst_hold),
    .link_up_i(link_up_i), .in_training_i(in_training_i), .speed_chg_i(speed_chg_i),
    .cur_speed_i(cur_speed_i), .max_speed_o(max_speed_o), .train_en_o(train_en_o),
    .speed_chg_req_o(speed_chg_req_o), .rx_data_ovrd_o(rx_data_ovrd_o),
    .rx_pll_ovrd_o(rx_pll_ovrd_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .speed_o(speed_o)
  );

  // link model, updated on the falling edge
  logic [15:0] m_up, m_chg, m_up2, m_cnt;
  logic [2:0]  m_ph;
  always @(negedge clk) begin
    if (!rst_n || !train_en_o) begin
      link_up_i <= 1'b0; in_training_i <= 1'b0; speed_chg_i <= 1'b0;
      m_cnt <= '0; m_ph <= '0;
      if (!rst_n) cur_speed_i <= 4'd0;
    end else begin
      case (m_ph)
        3'd0: begin
          in_training_i <= 1'b1;
          if (m_cnt >= m_up) begin
            link_up_i <= 1'b1; in_training_i <= 1'b0; cur_speed_i <= max_speed_o;
            m_ph <= 3'd1; m_cnt <= '0;
          end else m_cnt <= m_cnt + 1'b1;
        end
        3'd1: if (speed_chg_req_o) begin
          link_up_i <= 1'b0; in_training_i <= 1'b1; speed_chg_i <= 1'b1;
          m_ph <= 3'd2; m_cnt <= '0;
        end
        3'd2: if (m_cnt >= m_chg) begin
          speed_chg_i <= 1'b0; m_ph <= 3'd3; m_cnt <= '0;
        end else m_cnt <= m_cnt + 1'b1;
        3'd3: if (m_cnt >= m_up2) begin
          link_up_i <= 1'b1; in_training_i <= 1'b0; cur_speed_i <= max_speed_o;
          m_ph <= 3'd4;
        end else m_cnt <= m_cnt + 1'b1;
        default: ;
      endcase
    end
  end

  int total = 0, bad = 0;
  int train_bad_cap = 0;   // R2 monitor
  int req_bad_cap = 0;     // R4 monitor
  logic train_prev = 1'b0;
  always @(posedge clk) begin
    #2;
    if (rst_n && train_en_o && !train_prev && max_speed_o != 4'd1) train_bad_cap++;
    if (rst_n && speed_chg_req_o && max_speed_o != 4'd2) req_bad_cap++;
    train_prev = train_en_o;
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(); start = 1'b1; tick(); start = 1'b0; endtask

  int req_cycles, ovrd_cycles, ovrd_mismatch;
  task automatic run_to_end();
    req_cycles = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done_o || fail_o) break;
      tick();
      if (speed_chg_req_o) req_cycles++;
    end
    ovrd_cycles = 0; ovrd_mismatch = 0;
    if (rx_data_ovrd_o) ovrd_cycles++;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (rx_data_ovrd_o) ovrd_cycles++;
      if (rx_data_ovrd_o !== rx_pll_ovrd_o) ovrd_mismatch++;
    end
  endtask

  // gen2 | up_dly | chg_dly | up2_dly | exp_done | exp_speed
  localparam logic [53:0] VEC [0:6] = '{
    {1'b0, 16'd5,  16'd0,  16'd0,  1'b1, 4'd1},
    {1'b1, 16'd5,  16'd10, 16'd6,  1'b1, 4'd2},
    {1'b1, 16'd0,  16'd0,  16'd0,  1'b1, 4'd2},
    {1'b0, NEVER,  16'd0,  16'd0,  1'b0, 4'd0},
    {1'b1, 16'd3,  NEVER,  16'd0,  1'b0, 4'd0},
    {1'b1, 16'd3,  16'd5,  NEVER,  1'b0, 4'd0},
    {1'b1, 16'd20, 16'd30, 16'd12, 1'b1, 4'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_up = 16'd5; m_chg = 16'd0; m_up2 = 16'd0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 max_speed", 32'(max_speed_o), 1);
    chk("R1 train/req/ovrd", {train_en_o, speed_chg_req_o, rx_data_ovrd_o, rx_pll_ovrd_o}, 0);
    chk("R1 busy/done/fail/speed", {busy_o, done_o, fail_o, speed_o}, 0);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < 7; v++) begin
      logic [53:0] e;
      e = VEC[v];
      gen2_allow = e[53]; m_up = e[52:37]; m_chg = e[36:21]; m_up2 = e[20:5];
      pulse_start();
      run_to_end();
      chk(e[4] ? "R3/R5 done" : "R7 fail path", 32'({done_o, fail_o}), e[4] ? 2 : 1);
      chk("R3/R5 speed_o", 32'(speed_o), 32'(e[3:0]));
      chk("R3/R4 cap", 32'(max_speed_o), (e[53] && e[52:37] != NEVER) ? 2 : 1);
      if (!e[53]) chk("R3 no request", 32'(req_cycles), 0);
      if (!e[4]) begin
        chk("R8 override length", 32'(ovrd_cycles), HOLD);
        chk("R8 override pair", 32'(ovrd_mismatch), 0);
      end else chk("R8 no override on success", 32'(ovrd_cycles), 0);
      if (v == 4) chk("R6 request window", 32'(req_cycles), MAXP * (P_INT + 1));
    end
    chk("R2 train only at cap 1", 32'(train_bad_cap), 0);
    chk("R4 request only at cap 2", 32'(req_bad_cap), 0);

    // R7: link up but still training does not count
    gen2_allow = 1'b0; m_up = NEVER;
    pulse_start();
    repeat (10) tick();
    in_training_i = 1'b1;
    run_to_end();
    chk("R7 timeout fail", 32'(fail_o), 1);

    // R9: sticky done, cleared on accepted start
    gen2_allow = 1'b0; m_up = 16'd5;
    pulse_start();
    run_to_end();
    repeat (20) tick();
    chk("R9 done sticky", 32'({done_o, fail_o}), 2);
    start = 1'b1; tick(); start = 1'b0;
    chk("R9 done cleared on start", 32'(done_o), 0);
    run_to_end();
    chk("R9 rerun done", 32'(done_o), 1);

    // R10: start while sequence busy
    m_up = 16'd30;
    pulse_start();
    repeat (5) tick();
    chk("R10 busy during run", 32'(busy_o), 1);
    pulse_start();
    tick(); tick();
    chk("R10 train kept during busy start", 32'(train_en_o), 1);
    run_to_end();
    chk("R10 run unaffected", 32'(done_o), 1);

    // R10: start while receiver pulse active
    m_up = NEVER;
    pulse_start();
    for (int i = 0; i < 200; i++) begin
      if (fail_o) break;
      tick();
    end
    tick();
    chk("R10 busy during override", 32'(busy_o && rx_data_ovrd_o), 1);
    pulse_start();
    repeat (3) tick();
    chk("R10 fail kept", 32'({fail_o, train_en_o}), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule